// File: doc/BRIEF.md
# Busy Line Override Gate

This block sits between 32 incoming busy lines and the driver that fans them out. Every line has its own control register. That register selects one of three behaviours for the line. In pass mode the synchronized input goes through unchanged. In force-low mode the output is held at 0. In force-high mode the output is held at 1. Control codes are opaque byte values: 10 selects pass, 25 selects force-high, and every other value behaves as force-low.

Software reaches the registers over a small synchronous bus. Channel k (counting from 1) sits at address k-1, and two plain configuration bytes sit at addresses 37 and 38. A read of a channel returns its stored code, with bit 6 replaced by a status bit. That status bit is captured only when the channel's register is written, so software rewrites the same code just before each read to learn the present output level. Inputs pass through a two-flop synchronizer, and the outputs are registered.

Top module: `busy_gate`

## Requirements
- R1: After reset every code register holds 0, every output is low, rdata is 0, and both configuration bytes read 0.
- R2: With code 10 a channel's output follows its input with three clock edges of latency (two synchronizer stages plus the output register).
- R3: With code 0 a channel's output is low whatever its input.
- R4: With code 25 a channel's output is high whatever its input.
- R5: A code other than 0, 10 or 25 is stored and reads back, but the output is driven low.
- R6: After the clock edge that writes a code, the output takes the new behaviour at the following edge.
- R7: A read asserted at a clock edge updates rdata at that edge. For a channel, rdata bit 6 is the status bit and the other bits are the stored code. When rd_en is low, rdata holds its value.
- R8: The status bit is updated only by a write to its own channel. It captures the level that the newly written code gives with the current synchronized input. Later input changes do not alter it until the next write.
- R9: Addresses 37 and 38 are 8-bit registers that read back the last value written, and writing them has no effect on any output.
- R10: Reads of any address other than 0..31, 37 and 38 return 0. Writes to those addresses change no register and no output; in particular address 32 does not alias channel 1.
- R11: When a read and a write hit the same address at the same edge, the read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_in | input | 32 | Asynchronous busy lines, bit k-1 is channel k |
| busy_out | output | 32 | Registered gated lines |
| addr | input | 6 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rdata | output | 8 | Registered read data |

## Verification
The hardest case to reach from the ports is a status bit that has gone stale. In that case the readback disagrees with the live output, because the input moved after the last write. The stimulus programs a channel to pass while its input is high, then drops the input and waits until the output has followed. It then reads before any rewrite and expects the old high status, and reads again after rewriting the same code to see the fresh low value. Same-edge read/write collisions and a write to address 32 (one past the last channel, where a truncated decode would alias channel 1) are also driven on purpose.

// File: rtl/busy_gate_pkg.sv
package busy_gate_pkg;
    localparam int CODE_LOW  = 0;
    localparam int CODE_PASS = 10;
    localparam int CODE_HIGH = 25;

    typedef enum logic [1:0] {
        DRV_LOW  = 2'd0,
        DRV_PASS = 2'd1,
        DRV_HIGH = 2'd2
    } drive_e;
endpackage

// File: rtl/busy_gate_sync.sv
module busy_gate_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stage;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.stage[0] = d;
        for (int k = 1; k < STAGES; k++) begin
            s_d.stage[k] = s_q.stage[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q = s_q.stage[STAGES-1];
endmodule

// File: rtl/busy_gate_chan.sv
module busy_gate_chan
    import busy_gate_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              sync_in,
    output logic [DATA_W-1:0] mode,
    output logic              drive,
    output logic              seen
);
    typedef struct packed {
        logic [DATA_W-1:0] mode;
        logic              drive;
        logic              seen;
    } chan_t;

    chan_t c_d, c_q;

    function automatic drive_e classify(input logic [DATA_W-1:0] code);
        if (code == DATA_W'(CODE_PASS)) return DRV_PASS;
        if (code == DATA_W'(CODE_HIGH)) return DRV_HIGH;
        return DRV_LOW;
    endfunction

    function automatic logic level(input drive_e kind, input logic in);
        case (kind)
            DRV_PASS: return in;
            DRV_HIGH: return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

    always_comb begin
        c_d       = c_q;
        c_d.drive = level(classify(c_q.mode), sync_in);
        if (wr_sel) begin
            c_d.mode = wdata;
            c_d.seen = level(classify(wdata), sync_in);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign mode  = c_q.mode;
    assign drive = c_q.drive;
    assign seen  = c_q.seen;
endmodule

// File: rtl/busy_gate_regs.sv
module busy_gate_regs #(
    parameter int NUM_CH    = 32,
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 8,
    parameter int STATE_BIT = 6,
    parameter int CFG_A     = 37,
    parameter int CFG_B     = 38
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wdata,
    input  logic                           wr_en,
    input  logic                           rd_en,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  mode_v,
    input  logic [NUM_CH-1:0]              seen,
    output logic [NUM_CH-1:0]              wr_sel,
    output logic [DATA_W-1:0]              rdata
);
    localparam int CH_W = $clog2(NUM_CH);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic [DATA_W-1:0] cfg_a;
        logic [DATA_W-1:0] cfg_b;
    } regs_t;

    regs_t r_d, r_q;

    logic [CH_W-1:0] ch_idx;
    logic            in_ch;
    logic            hit_a;
    logic            hit_b;

    assign ch_idx = addr[CH_W-1:0];
    assign in_ch  = (int'(addr) < NUM_CH);
    assign hit_a  = (addr == ADDR_W'(CFG_A));
    assign hit_b  = (addr == ADDR_W'(CFG_B));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
        assign wr_sel[g] = wr_en && (addr == ADDR_W'(g));
    end

    always_comb begin
        r_d = r_q;
        if (rd_en) begin
            if (in_ch) begin
                r_d.rdata            = mode_v[ch_idx];
                r_d.rdata[STATE_BIT] = seen[ch_idx];
            end else if (hit_a) begin
                r_d.rdata = r_q.cfg_a;
            end else if (hit_b) begin
                r_d.rdata = r_q.cfg_b;
            end else begin
                r_d.rdata = '0;
            end
        end
        if (wr_en && hit_a) r_d.cfg_a = wdata;
        if (wr_en && hit_b) r_d.cfg_b = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata = r_q.rdata;
endmodule

// File: rtl/busy_gate.sv
module busy_gate #(
    parameter int NUM_CH      = 32,
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 8,
    parameter int STATE_BIT   = 6,
    parameter int CFG_A       = 37,
    parameter int CFG_B       = 38,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] busy_in,
    output logic [NUM_CH-1:0] busy_out,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata
);
    logic [NUM_CH-1:0]             sync_q;
    logic [NUM_CH-1:0][DATA_W-1:0] mode_v;
    logic [NUM_CH-1:0]             seen;
    logic [NUM_CH-1:0]             wr_sel;
    logic [NUM_CH-1:0]             drive;

    busy_gate_sync #(
        .WIDTH  (NUM_CH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (busy_in),
        .q     (sync_q)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        busy_gate_chan #(
            .DATA_W (DATA_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_sel  (wr_sel[i]),
            .wdata   (wdata),
            .sync_in (sync_q[i]),
            .mode    (mode_v[i]),
            .drive   (drive[i]),
            .seen    (seen[i])
        );
    end

    busy_gate_regs #(
        .NUM_CH    (NUM_CH),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .STATE_BIT (STATE_BIT),
        .CFG_A     (CFG_A),
        .CFG_B     (CFG_B)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .wdata  (wdata),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .mode_v (mode_v),
        .seen   (seen),
        .wr_sel (wr_sel),
        .rdata  (rdata)
    );

    assign busy_out = drive;
endmodule

// File: rtl/busy_gate_chk.sv
module busy_gate_chk
    import busy_gate_pkg::*;
#(
    parameter int NUM_CH      = 32,
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 8,
    parameter int STATE_BIT   = 6,
    parameter int CFG_A       = 37,
    parameter int CFG_B       = 38,
    parameter int SYNC_STAGES = 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_CH-1:0]             busy_in,
    input logic [NUM_CH-1:0]             busy_out,
    input logic [ADDR_W-1:0]             addr,
    input logic [DATA_W-1:0]             wdata,
    input logic                          wr_en,
    input logic                          rd_en,
    input logic [DATA_W-1:0]             rdata,
    input logic [NUM_CH-1:0]             sync_q,
    input logic [NUM_CH-1:0][DATA_W-1:0] mode_v,
    input logic [NUM_CH-1:0]             seen
);
    logic [1:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cyc_q <= '0;
        else if (cyc_q != 2'd3)  cyc_q <= cyc_q + 2'd1;
    end

    if (SYNC_STAGES == 2) begin : g_sync_chk
        // R2: synchronized copy lags the raw input by two edges
        a_r2_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
            (cyc_q == 2'd3) |-> (sync_q == $past(busy_in, 2)));
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan_chk
        a_r2_pass_follows: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_v[i] == DATA_W'(CODE_PASS)) |=> (busy_out[i] == $past(sync_q[i])));
        a_r3_force_low: assert property (@(posedge clk) disable iff (!rst_n)
            ((mode_v[i] != DATA_W'(CODE_PASS)) && (mode_v[i] != DATA_W'(CODE_HIGH)))
            |=> !busy_out[i]);
        a_r4_force_high: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_v[i] == DATA_W'(CODE_HIGH)) |=> busy_out[i]);
        a_r5_code_stored: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (addr == ADDR_W'(i))) |=> (mode_v[i] == $past(wdata)));
        a_r8_status_held: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (addr == ADDR_W'(i))) |=> $stable(seen[i]));
        a_r7_status_read: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && (addr == ADDR_W'(i))) |=> (rdata[STATE_BIT] == $past(seen[i])));
    end

    a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    a_r10_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (int'(addr) >= NUM_CH) && (addr != ADDR_W'(CFG_A)) && (addr != ADDR_W'(CFG_B)))
        |=> (rdata == '0));
endmodule

bind busy_gate busy_gate_chk #(
    .NUM_CH      (NUM_CH),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .STATE_BIT   (STATE_BIT),
    .CFG_A       (CFG_A),
    .CFG_B       (CFG_B),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_in  (busy_in),
    .busy_out (busy_out),
    .addr     (addr),
    .wdata    (wdata),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rdata    (rdata),
    .sync_q   (sync_q),
    .mode_v   (mode_v),
    .seen     (seen)
);

// File: tb/tb_busy_gate.sv
module tb_busy_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] busy_in = '1;
    logic [31:0] busy_out;
    logic [5:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    busy_gate dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy_in  (busy_in),
        .busy_out (busy_out),
        .addr     (addr),
        .wdata    (wdata),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .rdata    (rdata)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1", "outputs after reset", busy_out, 32'h0);
        check("R1", "rdata after reset", rdata, 32'h0);
        bus_read(6'd7, d);
        check("R1", "channel 8 code", d, 32'h0);
        bus_read(6'd37, d);
        check("R1", "config A", d, 32'h0);
        check("R3", "reset code forces low with inputs high", busy_out, 32'h0);
    endtask

    task automatic t_pass();
        bus_write(6'd0, 8'd10);
        check("R6", "old behaviour right after write edge", busy_out[0], 1'b0);
        @(negedge clk);
        check("R6", "pass takes effect next edge", busy_out[0], 1'b1);
        busy_in[0] = 1'b0;
        @(negedge clk);
        check("R2", "latency edge 1", busy_out[0], 1'b1);
        @(negedge clk);
        check("R2", "latency edge 2", busy_out[0], 1'b1);
        @(negedge clk);
        check("R2", "follows low at edge 3", busy_out[0], 1'b0);
        busy_in[0] = 1'b1;
        repeat (3) @(negedge clk);
        check("R2", "follows high at edge 3", busy_out[0], 1'b1);
    endtask

    task automatic t_force();
        bus_write(6'd1, 8'd0);
        repeat (3) @(negedge clk);
        check("R3", "force low with input high", busy_out[1], 1'b0);
        busy_in[2] = 1'b0;
        repeat (3) @(negedge clk);
        bus_write(6'd2, 8'd25);
        @(negedge clk);
        check("R4", "force high with input low", busy_out[2], 1'b1);
        busy_in[2] = 1'b1;
        repeat (3) @(negedge clk);
        busy_in[2] = 1'b0;
        repeat (3) @(negedge clk);
        check("R4", "force high after input toggles", busy_out[2], 1'b1);
    endtask

    task automatic t_unknown();
        logic [7:0] d;
        bus_write(6'd4, 8'h47);
        repeat (2) @(negedge clk);
        check("R5", "unknown code output", busy_out[4], 1'b0);
        bus_read(6'd4, d);
        check("R5", "unknown code reads back with bit 6 as status", d, 32'h07);
    endtask

    task automatic t_readback();
        logic [7:0] d;
        bus_write(6'd3, 8'd10);
        bus_read(6'd3, d);
        check("R7", "status high plus code", d, 32'h4A);
        busy_in[3] = 1'b0;
        repeat (4) @(negedge clk);
        check("R2", "channel 4 followed low", busy_out[3], 1'b0);
        bus_read(6'd3, d);
        check("R8", "stale status without rewrite", d, 32'h4A);
        repeat (3) @(negedge clk);
        check("R7", "rdata held while idle", rdata, 32'h4A);
        bus_write(6'd3, 8'd10);
        bus_read(6'd3, d);
        check("R8", "fresh status after rewrite", d, 32'h0A);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        @(negedge clk);
        addr = 6'd5; wdata = 8'd25; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R11", "read sees pre-write contents", rdata, 32'h00);
        bus_read(6'd5, d);
        check("R11", "following read sees new code", d, 32'h59);
    endtask

    task automatic t_cfg();
        logic [7:0] d;
        logic [31:0] snap;
        snap = busy_out;
        bus_write(6'd37, 8'h5A);
        bus_write(6'd38, 8'h00);
        bus_write(6'd38, 8'h33);
        bus_read(6'd37, d);
        check("R9", "config A readback", d, 32'h5A);
        bus_read(6'd38, d);
        check("R9", "config B readback", d, 32'h33);
        check("R9", "outputs untouched", busy_out, snap);
    endtask

    task automatic t_unused();
        logic [7:0] d;
        logic [31:0] snap;
        snap = busy_out;
        bus_write(6'd40, 8'd25);
        bus_write(6'd32, 8'd25);
        repeat (2) @(negedge clk);
        check("R10", "outputs untouched", busy_out, snap);
        bus_read(6'd40, d);
        check("R10", "address 40 reads 0", d, 32'h0);
        bus_read(6'd32, d);
        check("R10", "address 32 reads 0", d, 32'h0);
        bus_read(6'd63, d);
        check("R10", "address 63 reads 0", d, 32'h0);
        bus_read(6'd0, d);
        check("R10", "channel 1 not aliased by 32", d, 32'h4A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_pass();
        t_force();
        t_unknown();
        t_readback();
        t_collide();
        t_cfg();
        t_unused();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=complete");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule